// File: doc/BRIEF.md
# Bi-phase Backward Frame Transmitter

This block sends the one-byte reply that a lighting control gear returns on its two-wire bus after a forward frame that asks for an answer. A request carries the reply byte. The block then holds the bus released for a fixed settling gap. After the gap it sends a start bit, the eight data bits with the most significant bit first, and a released stop period. When the stop period ends it raises a one-cycle completion pulse, so that the receive path can be armed again.

Bits use bi-phase coding on the bus. A one is a low half followed by a high half, and a zero is a high half followed by a low half. Each half lasts one elementary period Te. The output drives the transmit stage, which shorts the bus when driven. A high output therefore means a low bus, and every half-cell level appears inverted on the pin. Te is counted in pulses of a 1 MHz tick enable. The reply byte comes from elsewhere, and the analog stage and collision detection are outside this block.

Top module: `bft_backward_tx`

## Requirements
- R1: While reset is held and after reset is released, `bus_pull`, `tx_busy` and `tx_done` are all 0.
- R2: When `reply_req` is 1 at a clock edge while the block is idle, `tx_busy` becomes 1 after that edge and `reply_byte` is captured as the data to send.
- R3: For the first SETTLE_TE periods of Te after acceptance, `bus_pull` stays 0. One Te is TE_TICKS pulses of `tick_1us` counted while busy, and the default of SETTLE_TE is 7.
- R4: The first bit after the gap is a start bit of value one: `bus_pull` is 1 for one Te, then 0 for one Te.
- R5: The eight data bits follow the start bit, bit 7 first. A bit of value 1 gives `bus_pull` 1 then 0, and a bit of value 0 gives 0 then 1, each half lasting one Te.
- R6: After the last data half, `bus_pull` stays 0 for STOP_TE periods of Te (default 4) before the frame ends.
- R7: A `reply_req` while `tx_busy` is 1 is ignored. The frame in progress keeps its timing and its originally captured byte.
- R8: At the end of the stop period, `tx_done` is 1 for exactly one cycle, in the same cycle `tx_busy` falls. A request made in that cycle is accepted.
- R9: The bus level changes only at Te boundaries. Pulses of `tick_1us` while idle, and one that coincides with acceptance, are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1us | input | 1 | One-cycle 1 MHz timing enable |
| reply_req | input | 1 | Request to send a reply frame |
| reply_byte | input | 8 | Byte to send, captured on acceptance |
| bus_pull | output | 1 | Transmit stage control, 1 shorts the bus low |
| tx_busy | output | 1 | A frame is in its gap, bits or stop period |
| tx_done | output | 1 | One-cycle pulse when the frame is complete |

## Verification
Two events can fall in the same cycle. One is the final Te strobe that ends the stop period. The other is a new send request, arriving either on that final strobe's edge or one cycle later, in the completion cycle. The bench forces a request with a different byte onto the last tick of each frame, where it must be ignored. It then issues the next frame's request during the `tx_done` cycle, where it must be accepted. That request is often paired with a tick, and the tick must not shorten the new gap. Judgement is made at the ports: the next waveform has to show the later byte, and its full gap, counted only from ticks after acceptance.

// File: rtl/bft_pkg.sv
package bft_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_DATA   = 2'd2,
    ST_STOP   = 2'd3
  } tx_state_e;
endpackage

// File: rtl/bft_rst_sync.sv
module bft_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= 1'b0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/bft_te_timer.sv
module bft_te_timer #(
  parameter int TE_TICKS = 417
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic te_o
);
  localparam int CNT_W = (TE_TICKS > 1) ? $clog2(TE_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TE_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == CNT_LAST);
  assign te_o    = run_i & tick_i & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R9
endmodule

// File: rtl/bft_shifter.sv
module bft_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              adv_i,
  input  logic              active_i,
  input  logic              second_half_i,
  output logic              drive_o
);
  localparam int FRAME_W = DATA_W + 1;

  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic               cur_bit;

  always_comb begin
    sreg_d = sreg_q;
    if (load_i) begin
      sreg_d = {1'b1, data_i};
    end else if (adv_i) begin
      sreg_d = {sreg_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_d;
  end

  assign cur_bit = sreg_q[FRAME_W-1];
  // bus low (pin high) in the first half of a one, pin inverted for the second half
  assign drive_o = active_i & (second_half_i ? ~cur_bit : cur_bit);
endmodule

// File: rtl/bft_ctrl.sv
module bft_ctrl
  import bft_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SETTLE_TE = 7,
  parameter int STOP_TE   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic te_i,
  output logic run_o,
  output logic load_o,
  output logic adv_o,
  output logic active_o,
  output logic second_half_o,
  output logic done_o
);
  localparam int HALVES = 2 * (DATA_W + 1);
  localparam int PH_MAX0 = (HALVES > SETTLE_TE) ? HALVES : SETTLE_TE;
  localparam int PH_MAX  = (PH_MAX0 > STOP_TE) ? PH_MAX0 : STOP_TE;
  localparam int PH_W    = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;
  localparam logic [PH_W-1:0] SETTLE_LAST = PH_W'(SETTLE_TE - 1);
  localparam logic [PH_W-1:0] HALF_LAST   = PH_W'(HALVES - 1);
  localparam logic [PH_W-1:0] STOP_LAST   = PH_W'(STOP_TE - 1);

  tx_state_e       state_q, state_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            done_q, done_d;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    adv_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          state_d = ST_SETTLE;
          phase_d = '0;
          load_o  = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (te_i) begin
          if (phase_q == SETTLE_LAST) begin
            state_d = ST_DATA;
            phase_d = '0;
          end else begin
            phase_d = phase_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (te_i) begin
          adv_o = phase_q[0];
          if (phase_q == HALF_LAST) begin
            state_d = ST_STOP;
            phase_d = '0;
          end else begin
            phase_d = phase_q + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (te_i) begin
          if (phase_q == STOP_LAST) begin
            state_d = ST_IDLE;
            phase_d = '0;
            done_d  = 1'b1;
          end else begin
            phase_d = phase_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign run_o         = (state_q != ST_IDLE);
  assign active_o      = (state_q == ST_DATA);
  assign second_half_o = phase_q[0];
  assign done_o        = done_q;

  AST_SETTLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE) |-> (phase_q <= SETTLE_LAST)); // R3
  AST_STOP_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> (phase_q <= STOP_LAST)); // R6
endmodule

// File: rtl/bft_backward_tx.sv
module bft_backward_tx #(
  parameter int TE_TICKS  = 417,
  parameter int SETTLE_TE = 7,
  parameter int STOP_TE   = 4,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1us,
  input  logic              reply_req,
  input  logic [DATA_W-1:0] reply_byte,
  output logic              bus_pull,
  output logic              tx_busy,
  output logic              tx_done
);
  logic rst_n_s;
  logic run, te_pulse, load, adv, active, second_half;

  bft_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  bft_te_timer #(.TE_TICKS(TE_TICKS)) i_te_timer (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run_i  (run),
    .tick_i (tick_1us),
    .te_o   (te_pulse)
  );

  bft_ctrl #(
    .DATA_W    (DATA_W),
    .SETTLE_TE (SETTLE_TE),
    .STOP_TE   (STOP_TE)
  ) i_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .req_i         (reply_req),
    .te_i          (te_pulse),
    .run_o         (run),
    .load_o        (load),
    .adv_o         (adv),
    .active_o      (active),
    .second_half_o (second_half),
    .done_o        (tx_done)
  );

  bft_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .load_i        (load),
    .data_i        (reply_byte),
    .adv_i         (adv),
    .active_i      (active),
    .second_half_i (second_half),
    .drive_o       (bus_pull)
  );

  assign tx_busy = run;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    tx_done |=> !tx_done); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n_s)
    tx_done |-> (!tx_busy && $past(tx_busy))); // R8
  AST_GAP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(tx_busy) |-> !bus_pull); // R3
  AST_LEVEL_ON_TE_ONLY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tx_busy && $past(tx_busy) && !$past(te_pulse)) |-> $stable(bus_pull)); // R9, also R7
endmodule

// File: tb/test_bft_backward_tx.sv
module test_bft_backward_tx;
  localparam int T   = 3;
  localparam int S   = 7;
  localparam int P   = 4;
  localparam int END = (S + 18 + P) * T;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_1us, reply_req;
  logic [7:0] reply_byte;
  logic       bus_pull, tx_busy, tx_done;

  int tests = 0;
  int fails = 0;

  bit       m_busy = 1'b0;
  bit       m_done = 1'b0;
  int       m_k = 0;
  bit [7:0] m_data = 8'h00;
  bit       stray_seen = 1'b0;

  always #4 clk = ~clk;

  bft_backward_tx #(.TE_TICKS(T)) i_bft_backward_tx (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .reply_req(reply_req),
    .reply_byte(reply_byte), .bus_pull(bus_pull), .tx_busy(tx_busy), .tx_done(tx_done)
  );

  function automatic bit exp_pull(int k, bit [7:0] d);
    int e = k / T;
    int n;
    bit fb;
    if (e < S) return 1'b0;
    n = e - S;
    if (n >= 18) return 1'b0;
    fb = (n / 2 == 0) ? 1'b1 : d[8 - n / 2];
    return (n % 2 == 0) ? fb : ~fb;
  endfunction

  function automatic string region_tag(int k);
    int e = k / T;
    if (e < S) return "R3";
    if (e < S + 2) return "R4";
    if (e < S + 18) return "R5";
    return "R6";
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit t, bit r, bit [7:0] d);
    @(negedge clk);
    tick_1us = t; reply_req = r; reply_byte = d;
    @(posedge clk);
    if (m_busy) begin
      m_done = 1'b0;
      if (t) begin
        m_k++;
        if (m_k == END) begin m_busy = 1'b0; m_done = 1'b1; end
      end
    end else begin
      m_done = 1'b0;
      if (r) begin m_busy = 1'b1; m_k = 0; m_data = d; stray_seen = 1'b0; end
    end
    #2;
    chk(m_busy ? "R2" : "R8", tx_busy, m_busy);
    chk("R8", tx_done, m_done);
    if (m_busy) chk(stray_seen ? "R7" : region_tag(m_k), bus_pull, exp_pull(m_k, m_data));
    else        chk("R9", bus_pull, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit [7:0] d;
    bit t;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; tick_1us = 1'b0; reply_req = 1'b0; reply_byte = 8'h00;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", bus_pull, 0); chk("R1", tx_busy, 0); chk("R1", tx_done, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", bus_pull, 0); chk("R1", tx_busy, 0); chk("R1", tx_done, 0);
    // R9: ticks while idle must not advance anything
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 8'h00);
    for (int f = 0; f < 16; f++) begin
      case (f)
        0: d = 8'h00;
        1: d = 8'hFF;
        2: d = 8'hA5;
        3: d = 8'h5A;
        default: d = 8'($urandom);
      endcase
      // R8/R9: request in the done cycle, often with a tick that must not count
      step(bit'($urandom % 2), 1'b1, d);
      while (m_busy) begin
        if (m_k == END - 1) begin
          // R7: request on the very edge that ends the stop period is ignored
          t = ($urandom % 2 == 0);
          step(t, 1'b1, ~m_data);
        end else begin
          t = ($urandom % 3 == 0);
          if ($urandom % 9 == 0) begin
            step(t, 1'b1, 8'($urandom)); // R7: stray request while busy
            stray_seen = 1'b1;
          end else begin
            step(t, 1'b0, 8'h00);
          end
        end
      end
      if (f % 4 == 3) begin
        for (int i = 0; i < 8; i++) step(bit'($urandom % 2), 1'b0, 8'h00);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule